// File: doc/BRIEF.md
# Inter-Processor Mailbox Channel Controller

This block lets processors on one chip pass short messages to each other through a set of register-mapped mailbox channels. There are `NCH` channels, four by default and at most 32. Each channel holds eight 32-bit message words. It also holds an owner bit, a destination interrupt bit, a mask, and a small state machine that moves the channel through idle, ready, sent and acknowledged. A processor unlocks the block with a key and claims an idle channel by writing its own one-hot interrupt bit as the owner. It then names the receiver and fills the message words. Writing its bit to the send register raises the receiver's interrupt.

The receiver clears the pending destination bit. In automatic-acknowledge mode that clear moves the channel to the acknowledged state and raises the owner's interrupt line. The owner then clears that interrupt, which returns the channel to ready for the next message. All interrupt lines from all channels are merged into one 32-line vector. Access is through a simple synchronous register bus with word-aligned byte addresses. Each channel has a 64-byte window at `channel * 0x40`, and the lock register sits at 0xA00. Read data appears on the cycle after the read request.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the lock register (0xA00) reads 1, every channel's mode word (offset 0x10) reads 0x10 (idle), every mask (offset 0x14) reads 0xFFFFFFFF, and `irq_out` is 0.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block, after which 0xA00 reads 0. Writing any other value there locks it again, after which it reads 1.
- R3: While locked, writes to the owner (0x00), destination (0x04) and mode (0x10) registers leave them unchanged.
- R4: A write of a one-hot value to the owner register is taken only while the channel is idle. It then reads back, and the mode word shows bit 5 (ready) in place of bit 4 (idle). Owner writes of a value that is not one-hot, and owner writes to a channel that is not idle, are ignored.
- R5: Writing a value to send (0x1C) that shares a bit with the owner, while the channel is ready, ORs the destination into the pending destination bits. These bits read at 0x0C. The mode word then shows neither bit 4, bit 5 nor bit 7. A send in any other case is ignored.
- R6: `irq_out` is the OR over all channels of (pending destination bits | pending acknowledge bits) & ~mask. It changes on the same clock edge that takes the triggering write.
- R7: A mask bit of 1 keeps the matching pending bit off `irq_out`. Clearing the mask bit exposes the pending bit again.
- R8: With mode bit 0 set (automatic acknowledge), writing 1s to 0x08 that clear the last pending destination bit moves the channel to acknowledged. The mode word shows bit 7, and the owner's bit becomes a pending acknowledge bit.
- R9: With mode bit 0 clear, the same clear returns the channel straight to ready, and no acknowledge bit is raised.
- R10: In the acknowledged state, writing the owner's bit to interrupt clear (0x18) drops the acknowledge bit and returns the channel to ready.
- R11: Writing 0 to the owner register while unlocked releases the channel to idle and drops all its pending bits.
- R12: The eight message words at 0x20 to 0x3C of each channel are written and read back independently of those of every other channel.
- R13: `bus_rdata` holds the addressed word on the cycle after the read request. Addresses that reach no channel and are not the lock register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_out | output | 32 | Merged interrupt vector |

## Verification
The hardest state to reach from the ports is the acknowledged state. To get there the bench must unlock the block and claim the channel. It must also set a destination, select automatic acknowledge, unmask both lines and send, and only then clear the destination bit. The bench runs that full sequence on one channel and checks the interrupt vector after each write. It then sends again with everything masked, so that a pending bit is held hidden and is exposed later by unmasking. A second channel runs the manual-acknowledge path, which shows that the two modes split only at the destination clear.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DW        = 32;
    localparam int MSG_WORDS = 8;
    localparam int WIN_BITS  = 6;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
    localparam int LOCK_BYTE = 'hA00;

    localparam logic [3:0] OFF_OWNER = 4'd0;
    localparam logic [3:0] OFF_DEST  = 4'd1;
    localparam logic [3:0] OFF_DCLR  = 4'd2;
    localparam logic [3:0] OFF_DPEND = 4'd3;
    localparam logic [3:0] OFF_MODE  = 4'd4;
    localparam logic [3:0] OFF_MASK  = 4'd5;
    localparam logic [3:0] OFF_ICLR  = 4'd6;
    localparam logic [3:0] OFF_SEND  = 4'd7;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_READY = 2'd1,
        CH_SENT  = 2'd2,
        CH_ACKED = 2'd3
    } chan_state_e;

    function automatic logic is_onehot(input logic [DW-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [DW-1:0] mode_word(input chan_state_e st, input logic auto_ack);
        logic [DW-1:0] w;
        w    = '0;
        w[0] = auto_ack;
        w[4] = (st == CH_IDLE);
        w[5] = (st == CH_READY);
        w[7] = (st == CH_ACKED);
        return w;
    endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NCH-1:0]    ch_sel,
    output logic [3:0]        word_off,
    output logic              lock_hit
);
    localparam int IDX_W = ADDR_W - WIN_BITS;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx      = bus_addr[ADDR_W-1:WIN_BITS];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_off = bus_addr[WIN_BITS-1:2];
    assign lock_hit = bus_en && (bus_addr == ADDR_W'(LOCK_BYTE));

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign ch_sel[i] = bus_en && aligned && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/mbox_lock.sv
module mbox_lock
    import mbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          unlocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (wr) begin
            unlocked <= (wdata == UNLOCK_KEY);
        end
    end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
    import mbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          we,
    input  logic [3:0]    off,
    input  logic [DW-1:0] wdata,
    input  logic          unlocked,
    output logic [DW-1:0] rd_word,
    output logic [DW-1:0] irq_vec,
    output logic [DW-1:0] owner_o,
    output chan_state_e   state_o
);
    chan_state_e                 st;
    logic [DW-1:0]               owner, dest, dpend, apend, mask;
    logic                        auto_ack;
    logic [MSG_WORDS-1:0][DW-1:0] msg;
    logic                        wr;
    logic [DW-1:0]               dpend_left;

    assign wr         = sel && we;
    assign dpend_left = dpend & ~wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CH_IDLE;
            owner    <= '0;
            dest     <= '0;
            dpend    <= '0;
            apend    <= '0;
            mask     <= '1;
            auto_ack <= 1'b0;
            msg      <= '0;
        end else if (wr) begin
            case (off)
                OFF_OWNER: begin
                    if (unlocked) begin
                        if (wdata == '0) begin
                            owner <= '0;
                            st    <= CH_IDLE;
                            dpend <= '0;
                            apend <= '0;
                        end else if (st == CH_IDLE && is_onehot(wdata)) begin
                            owner <= wdata;
                            st    <= CH_READY;
                        end
                    end
                end
                OFF_DEST: begin
                    if (unlocked) dest <= wdata;
                end
                OFF_DCLR: begin
                    dpend <= dpend_left;
                    if (st == CH_SENT && (dpend & wdata) != '0 && dpend_left == '0) begin
                        if (auto_ack) begin
                            st    <= CH_ACKED;
                            apend <= apend | owner;
                        end else begin
                            st <= CH_READY;
                        end
                    end
                end
                OFF_MODE: begin
                    if (unlocked) auto_ack <= wdata[0];
                end
                OFF_MASK: begin
                    mask <= wdata;
                end
                OFF_ICLR: begin
                    apend <= apend & ~wdata;
                    if (st == CH_ACKED && (wdata & owner) != '0) st <= CH_READY;
                end
                OFF_SEND: begin
                    if (st == CH_READY && (wdata & owner) != '0) begin
                        dpend <= dpend | dest;
                        st    <= CH_SENT;
                    end
                end
                default: begin
                    msg[off[2:0]] <= wdata;
                end
            endcase
        end
    end

    always_comb begin
        case (off)
            OFF_OWNER: rd_word = owner;
            OFF_DEST:  rd_word = dest;
            OFF_DCLR:  rd_word = '0;
            OFF_DPEND: rd_word = dpend;
            OFF_MODE:  rd_word = mode_word(st, auto_ack);
            OFF_MASK:  rd_word = mask;
            OFF_ICLR:  rd_word = '0;
            OFF_SEND:  rd_word = '0;
            default:   rd_word = msg[off[2:0]];
        endcase
    end

    assign irq_vec = (dpend | apend) & ~mask;
    assign owner_o = owner;
    assign state_o = st;
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       irq_out
);
    logic [NCH-1:0]         ch_sel;
    logic [3:0]             word_off;
    logic                   lock_hit;
    logic                   unlocked;
    logic [NCH-1:0][DW-1:0] ch_rd, ch_irq, ch_owner;
    logic [NCH-1:0][1:0]    ch_st;
    logic [DW-1:0]          rd_next, irq_next;

    mbox_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .bus_en  (bus_en),
        .bus_addr(bus_addr),
        .ch_sel  (ch_sel),
        .word_off(word_off),
        .lock_hit(lock_hit)
    );

    mbox_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .wr      (lock_hit && bus_we),
        .wdata   (bus_wdata),
        .unlocked(unlocked)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_state_e st_i;
        mbox_chan u_ch (
            .clk     (clk),
            .rst     (rst),
            .sel     (ch_sel[i]),
            .we      (bus_we),
            .off     (word_off),
            .wdata   (bus_wdata),
            .unlocked(unlocked),
            .rd_word (ch_rd[i]),
            .irq_vec (ch_irq[i]),
            .owner_o (ch_owner[i]),
            .state_o (st_i)
        );
        assign ch_st[i] = st_i;
    end

    always_comb begin
        rd_next  = lock_hit ? {31'b0, ~unlocked} : '0;
        irq_next = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) rd_next = rd_next | ch_rd[i];
            irq_next = irq_next | ch_irq[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_en && !bus_we) begin
            bus_rdata <= rd_next;
        end
    end

    assign irq_out = irq_next;
endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              unlocked,
    input logic [31:0]       owner0,
    input logic [1:0]        st0
);
    logic lock_acc, own0_wr;
    assign lock_acc = bus_en && (bus_addr == ADDR_W'(LOCK_BYTE));
    assign own0_wr  = bus_en && bus_we && (bus_addr == '0);

    assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (rst)
        (lock_acc && bus_we && bus_wdata == UNLOCK_KEY) |=> unlocked);

    assert_other_relocks_R2: assert property (@(posedge clk) disable iff (rst)
        (lock_acc && bus_we && bus_wdata != UNLOCK_KEY) |=> !unlocked);

    assert_locked_owner_R3: assert property (@(posedge clk) disable iff (rst)
        (own0_wr && !unlocked) |=> $stable(owner0));

    assert_lock_readback_R13: assert property (@(posedge clk) disable iff (rst)
        (lock_acc && !bus_we) |=> (bus_rdata == {31'b0, !$past(unlocked)}));

    assert_owner_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner0));

    assert_claim_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (owner0 != '0 && $past(owner0) == '0) |-> ($past(st0) == 2'(CH_IDLE)));

    assert_sent_from_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (st0 == 2'(CH_SENT) && $past(st0) != 2'(CH_SENT)) |-> ($past(st0) == 2'(CH_READY)));

    assert_ack_from_sent_R8: assert property (@(posedge clk) disable iff (rst)
        (st0 == 2'(CH_ACKED) && $past(st0) != 2'(CH_ACKED)) |-> ($past(st0) == 2'(CH_SENT)));
endmodule

bind mbox_ctrl mbox_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .unlocked (unlocked),
    .owner0   (ch_owner[0]),
    .st0      (ch_st[0])
);

// File: tb/mbox_ctrl_bench.sv
`timescale 1ns/1ps
module mbox_ctrl_bench;
    localparam int ADDR_W = 12;
    localparam logic [31:0] KEY = 32'h1ACC_E551;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       irq_out;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    mbox_ctrl #(.NCH(4), .ADDR_W(ADDR_W)) u_mbox_ctrl (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic chk_irq(input logic [31:0] e, input string tag);
        checks++;
        if (irq_out !== e) begin
            failures++;
            $display("FAIL %s irq_out actual=%h expected=%h", tag, irq_out, e);
        end
    endtask

    // monitor: compares read data one edge after the request
    always @(posedge clk) begin
        if (bus_en && !bus_we) begin
            logic [31:0] e;
            string t;
            #1;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        #1600000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(32'h0, "R1");
        rd(12'hA00, 32'h1, "R1 lock");
        rd(12'h010, 32'h10, "R1 mode ch0");
        rd(12'h0D0, 32'h10, "R1 mode ch3");
        rd(12'h014, 32'hFFFF_FFFF, "R1 mask");
        // R3 locked writes ignored
        wr(12'h000, 32'h1);
        rd(12'h000, 32'h0, "R3 owner");
        wr(12'h004, 32'h4);
        rd(12'h004, 32'h0, "R3 dest");
        wr(12'h010, 32'h1);
        rd(12'h010, 32'h10, "R3 mode");
        // R2 lock key
        wr(12'hA00, KEY);
        rd(12'hA00, 32'h0, "R2 unlock");
        wr(12'hA00, 32'h5);
        rd(12'hA00, 32'h1, "R2 relock");
        wr(12'hA00, KEY);
        rd(12'hA00, 32'h0, "R2 unlock again");
        // R4 claim
        wr(12'h000, 32'h3);
        rd(12'h000, 32'h0, "R4 not one-hot");
        wr(12'h000, 32'h2);
        rd(12'h000, 32'h2, "R4 claim");
        rd(12'h010, 32'h20, "R4 ready");
        wr(12'h000, 32'h8);
        rd(12'h000, 32'h2, "R4 busy claim");
        // R5 send gating
        wr(12'h05C, 32'h1);
        rd(12'h04C, 32'h0, "R5 unowned send");
        wr(12'h004, 32'h10);
        wr(12'h010, 32'h1);
        wr(12'h014, 32'hFFFF_FFED);
        wr(12'h01C, 32'h1);
        rd(12'h00C, 32'h0, "R5 wrong bit send");
        wr(12'h01C, 32'h2);
        chk_irq(32'h10, "R6 dest irq");
        rd(12'h00C, 32'h10, "R5 pending");
        rd(12'h010, 32'h1, "R5 sent mode");
        // R8 auto ack
        wr(12'h008, 32'h10);
        chk_irq(32'h2, "R8 ack irq");
        rd(12'h010, 32'h81, "R8 acked mode");
        rd(12'h00C, 32'h0, "R8 pending cleared");
        // R10 interrupt clear
        wr(12'h018, 32'h2);
        chk_irq(32'h0, "R10 irq dropped");
        rd(12'h010, 32'h21, "R10 ready");
        // R7 mask
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h01C, 32'h2);
        chk_irq(32'h0, "R7 masked");
        rd(12'h00C, 32'h10, "R7 pending hidden");
        wr(12'h014, 32'hFFFF_FFED);
        chk_irq(32'h10, "R7 unmasked");
        // R11 release
        wr(12'h000, 32'h0);
        chk_irq(32'h0, "R11 irq");
        rd(12'h010, 32'h11, "R11 idle");
        rd(12'h00C, 32'h0, "R11 pending");
        // R9 manual mode on ch2
        wr(12'h080, 32'h4);
        wr(12'h084, 32'h1);
        wr(12'h094, 32'hFFFF_FFFA);
        wr(12'h09C, 32'h4);
        chk_irq(32'h1, "R9 dest irq");
        wr(12'h088, 32'h1);
        chk_irq(32'h0, "R9 no ack");
        rd(12'h090, 32'h20, "R9 ready");
        // R12 message words
        for (int i = 0; i < 8; i++) begin
            wr(ADDR_W'(12'h020 + 4*i), 32'hA5A5_0000 + i);
            wr(ADDR_W'(12'h0E0 + 4*i), 32'h5A5A_0100 + i);
        end
        for (int i = 0; i < 8; i++) begin
            rd(ADDR_W'(12'h020 + 4*i), 32'hA5A5_0000 + i, "R12 ch0 word");
            rd(ADDR_W'(12'h0E0 + 4*i), 32'h5A5A_0100 + i, "R12 ch3 word");
        end
        // R13 unmapped
        rd(12'h200, 32'h0, "R13 beyond channels");
        rd(12'hA04, 32'h0, "R13 near lock");
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule